// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a parallel NOR-style flash. Once the host has launched a program or an erase, the poller decides when the flash has finished writing internally. There are three ways to tell, chosen when the poll is started. It can watch a ready/busy level. It can read back bit 7 and compare it with the value it should settle to. It can read back bit 6 and wait until it stops flipping.

The host pulses `start` at the beginning of the command sequence. It then gives one `we_edge` pulse for every rising edge of the flash's write-enable line. Polling begins only when enough edges have been seen for the operation type. Status reads go out over a plain request/acknowledge read port.

A status read that looks finished is not trusted on its own, because the flash can finish at the same moment the read is taken. The poller makes two more reads of the same location. It reports success only if both return the real stored word. If either one does not, the write is reported as rejected. A cycle budget loaded at start bounds the whole poll.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done`, `error` and `rd_req` are all low.
- R2: `start` latches `op_type` (0 = program, 1 = erase), `mode`, `expected_data` and `timeout_cycles`. No status read is issued, and a high `busy_n` is not acted on, until `we_edge` has pulsed 4 times (program) or 6 times (erase) after the start cycle. The first read request appears one cycle after the last counted pulse.
- R3: With `mode` = 0 (ready/busy), no reads are issued. Once the pulse count is reached, the first cycle in which `busy_n` is sampled high ends the poll. `done` is then high in the following cycle with `error` low.
- R4: With `mode` = 1 and a program, a read looks finished when its bit 7 equals bit 7 of `expected_data`. Any other read is followed by another poll read.
- R5: With `mode` = 1 and an erase, a read looks finished when its bit 7 is 1. A 0 keeps polling.
- R6: After a read that looks finished, exactly two more reads are made. `done` is raised with `error` low only if both return the full settled word. For a program that word is `expected_data`; for an erase it is all ones. Otherwise `done` is raised with `error` high.
- R7: With `mode` = 2 or 3 (toggle), the first poll read is only stored. Each later poll read looks finished when its bit 6 equals bit 6 of the previous poll read. A differing bit 6 keeps polling.
- R8: If the poll has not ended within `timeout_cycles`+1 cycles after the start cycle, it is aborted with `done` and `error` both high. This takes priority over a completion in the same cycle.
- R9: `start` has no effect while a poll is active, and the inputs latched at start stay in force.
- R10: `done` is a one-cycle pulse, given exactly once per poll, and `error` is never high without `done`.
- R11: `rd_req` stays high until `rd_ack` is sampled. Each sampled `rd_ack` completes exactly one read, with `rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (honoured only when idle) |
| op_type | input | 1 | 0 = program, 1 = erase |
| mode | input | 2 | 0 ready/busy, 1 bit-7 polling, 2 or 3 bit-6 toggle |
| expected_data | input | DW | Word that was programmed |
| timeout_cycles | input | TW | Cycle budget for the poll |
| we_edge | input | 1 | One pulse per write-enable rising edge |
| busy_n | input | 1 | Ready/busy level, low while busy (already synchronised) |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read completed, `rdata` valid |
| rdata | input | DW | Data returned by the read |
| done | output | 1 | One-cycle end-of-poll pulse |
| error | output | 1 | Rejection or timeout, valid with `done` |

## Verification
Each result has a fixed due cycle, counted in edges after the edge that samples `start`:
- The first read request is due at pulse count + 1.
- A poll that ends on its read number k (counted from 0) raises `done` at pulse count + 1 + (k+1)·(latency+1).
- In ready/busy mode, `done` is due at pulse count + 1 + max(b,1), where b is the edge after the pulses at which `busy_n` is raised.
- A timeout raises `done` at budget + 1.

The bench computes these figures with its own arithmetic from the read script it feeds in. It samples at the falling edge and compares the exact cycle in which `done` appeared against the computed one. It also checks the number of reads consumed and the cycle of the first request.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  typedef enum logic [1:0] {
    PM_READY = 2'd0,
    PM_BIT7  = 2'd1,
    PM_BIT6  = 2'd2
  } poll_mode_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } flash_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RDYWAIT,
    ST_READ
  } poll_state_e;

  typedef enum logic [1:0] {
    PH_POLL,
    PH_CONF1,
    PH_CONF2
  } read_phase_e;

  // Mode code 3 is folded onto toggle polling.
  function automatic poll_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd0:    return PM_READY;
      2'd1:    return PM_BIT7;
      default: return PM_BIT6;
    endcase
  endfunction

endpackage

// File: rtl/fdp_pulse_gate.sv
module fdp_pulse_gate #(
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic we_edge,
  input  logic is_erase,
  output logic reached
);
  localparam int MAXP = (PROG_PULSES > ERASE_PULSES) ? PROG_PULSES : ERASE_PULSES;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;

  assign need    = is_erase ? CW'(ERASE_PULSES) : CW'(PROG_PULSES);
  assign reached = (cnt_q >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (we_edge && !reached) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fdp_timer.sv
module fdp_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && !zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fdp_judge.sv
module fdp_judge
  import fdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  flash_op_e        op,
  input  poll_mode_e       mode,
  input  logic [DW-1:0]    expected,
  input  logic [DW-1:0]    rdata,
  input  logic             have_prev,
  input  logic             prev_b6,
  output logic             looks_done,
  output logic             word_ok
);
  // A poll read that suggests the write has ended.
  function automatic logic f_poll_hit(input flash_op_e o, input poll_mode_e m,
                                      input logic [DW-1:0] ex, input logic [DW-1:0] rd,
                                      input logic hp, input logic pb);
    logic settled_b7;
    settled_b7 = (o == OP_ERASE) ? 1'b1 : ex[7];
    if (m == PM_BIT7) return rd[7] == settled_b7;
    return hp && (rd[6] == pb);
  endfunction

  // A confirmation read carrying the word the cells should now hold.
  function automatic logic f_word_ok(input flash_op_e o, input logic [DW-1:0] ex,
                                     input logic [DW-1:0] rd);
    logic [DW-1:0] settled;
    settled = (o == OP_ERASE) ? {DW{1'b1}} : ex;
    return rd == settled;
  endfunction

  assign looks_done = f_poll_hit(op, mode, expected, rdata, have_prev, prev_b6);
  assign word_ok    = f_word_ok(op, expected, rdata);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int DW           = 8,
  parameter int TW           = 16,
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_type,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] expected_data,
  input  logic [TW-1:0] timeout_cycles,
  input  logic          we_edge,
  input  logic          busy_n,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rdata,
  output logic          done,
  output logic          error
);
  poll_state_e   state_q, state_d;
  read_phase_e   phase_q;
  flash_op_e     op_q;
  poll_mode_e    mode_q;
  logic [DW-1:0] exp_q;
  logic          have_prev_q, prev_b6_q, conf_bad_q;
  logic          done_q, err_q;

  // Named internal events, also observed by the checker.
  logic accept, active, gate_reached, tmr_zero, expire;
  logic rd_take, looks_done, word_ok, finish, finish_bad, mode_is_rdy;

  assign accept      = start && (state_q == ST_IDLE);
  assign active      = (state_q != ST_IDLE);
  assign expire      = active && tmr_zero;
  assign rd_take     = (state_q == ST_READ) && rd_ack;
  assign mode_is_rdy = (mode_q == PM_READY);

  fdp_pulse_gate #(
    .PROG_PULSES (PROG_PULSES),
    .ERASE_PULSES(ERASE_PULSES)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .we_edge (we_edge),
    .is_erase(op_q == OP_ERASE),
    .reached (gate_reached)
  );

  fdp_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(timeout_cycles),
    .run     (active),
    .zero    (tmr_zero)
  );

  fdp_judge #(.DW(DW)) u_judge (
    .op        (op_q),
    .mode      (mode_q),
    .expected  (exp_q),
    .rdata     (rdata),
    .have_prev (have_prev_q),
    .prev_b6   (prev_b6_q),
    .looks_done(looks_done),
    .word_ok   (word_ok)
  );

  always_comb begin
    state_d    = state_q;
    finish     = 1'b0;
    finish_bad = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (expire) begin
          finish     = 1'b1;
          finish_bad = 1'b1;
        end else if (gate_reached) begin
          state_d = mode_is_rdy ? ST_RDYWAIT : ST_READ;
        end
      end
      ST_RDYWAIT: begin
        if (expire) begin
          finish     = 1'b1;
          finish_bad = 1'b1;
        end else if (busy_n) begin
          finish = 1'b1;
        end
      end
      ST_READ: begin
        if (expire) begin
          finish     = 1'b1;
          finish_bad = 1'b1;
        end else if (rd_ack && (phase_q == PH_CONF2)) begin
          finish     = 1'b1;
          finish_bad = conf_bad_q | ~word_ok;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_POLL;
      op_q        <= OP_PROGRAM;
      mode_q      <= PM_READY;
      exp_q       <= '0;
      have_prev_q <= 1'b0;
      prev_b6_q   <= 1'b0;
      conf_bad_q  <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      err_q   <= finish_bad;
      if (accept) begin
        op_q        <= flash_op_e'(op_type);
        mode_q      <= decode_mode(mode);
        exp_q       <= expected_data;
        phase_q     <= PH_POLL;
        have_prev_q <= 1'b0;
        prev_b6_q   <= 1'b0;
        conf_bad_q  <= 1'b0;
      end else if (rd_take && !expire) begin
        unique case (phase_q)
          PH_POLL: begin
            if (looks_done) begin
              phase_q <= PH_CONF1;
            end else begin
              have_prev_q <= 1'b1;
              prev_b6_q   <= rdata[6];
            end
          end
          PH_CONF1: begin
            conf_bad_q <= ~word_ok;
            phase_q    <= PH_CONF2;
          end
          default: phase_q <= PH_POLL;
        endcase
      end
    end
  end

  assign rd_req = (state_q == ST_READ);
  assign done   = done_q;
  assign error  = err_q;
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic error,
  input logic rd_req,
  input logic rd_ack,
  input logic active,
  input logic gate_reached,
  input logic expire,
  input logic finish,
  input logic mode_is_rdy
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_error_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  p_read_after_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> gate_reached);

  p_ready_mode_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_rdy && active) |-> !rd_req);

  p_timeout_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (done && error));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && !finish) |=> active);

  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !expire) |=> rd_req);
endmodule

bind flash_done_poller fdp_checker u_fdp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .error       (error),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .active      (active),
  .gate_reached(gate_reached),
  .expire      (expire),
  .finish      (finish),
  .mode_is_rdy (mode_is_rdy)
);

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       op_type = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] expected_data = 8'h00;
  logic [15:0] timeout_cycles = 16'd0;
  logic       we_edge = 1'b0;
  logic       busy_n = 1'b0;
  logic       rd_req;
  logic       rd_ack = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic       done, error;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] scr [32];
  int scr_len = 1;
  int rd_idx = 0;
  int rsp_lat = 0;
  int rsp_wait = 0;

  always #5 clk = ~clk;

  flash_done_poller #(.DW(8), .TW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_type(op_type), .mode(mode),
    .expected_data(expected_data), .timeout_cycles(timeout_cycles),
    .we_edge(we_edge), .busy_n(busy_n), .rd_req(rd_req), .rd_ack(rd_ack),
    .rdata(rdata), .done(done), .error(error)
  );

  // Flash read responder: answers after rsp_lat idle cycles, replaying the script.
  always @(negedge clk) begin
    if (rd_req) begin
      if (rsp_wait >= rsp_lat) begin
        rd_ack   = 1'b1;
        rdata    = scr[(rd_idx < scr_len) ? rd_idx : scr_len - 1];
        rd_idx   = rd_idx + 1;
        rsp_wait = 0;
      end else begin
        rd_ack   = 1'b0;
        rsp_wait = rsp_wait + 1;
      end
    end else begin
      rd_ack   = 1'b0;
      rsp_wait = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      check(1'b0, "watchdog", "cycles", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [7:0] sread(input int i);
    return scr[(i < scr_len) ? i : scr_len - 1];
  endfunction

  // Index of the final confirmation read and the verdict, from the requirements.
  task automatic model(input int md, input int op, input logic [7:0] ex,
                       output int last, output bit bad);
    logic [7:0] want;
    logic b7;
    int c;
    want = (op == 1) ? 8'hFF : ex;
    b7   = (op == 1) ? 1'b1 : ex[7];
    c = -1;
    for (int i = 0; i < scr_len; i++) begin
      bit hit;
      if (md == 1) hit = (scr[i][7] == b7);
      else         hit = (i > 0) && (scr[i][6] == scr[i-1][6]);
      if (hit && c < 0) c = i;
    end
    if (c < 0) begin
      last = 1000;
      bad  = 1'b1;
    end else begin
      last = c + 2;
      bad  = (sread(c + 1) != want) || (sread(c + 2) != want);
    end
  endtask

  task automatic run(input string tag, input int md, input int op, input logic [7:0] ex,
                     input int tmo, input int bwait, input int lat, input bit inj);
    int n, last, exp_edge, first_req, done_seen, done_at, stray, err_seen;
    bit exp_err, tmo_hit;
    n = (op == 1) ? 6 : 4;
    first_req = -1; done_seen = 0; done_at = -1; stray = 0; err_seen = 0;
    tmo_hit = 1'b0; last = 0;
    rsp_lat = lat;
    rd_idx  = 0;
    busy_n  = (md == 0) && (bwait == 0);
    start = 1'b1; op_type = op[0]; mode = md[1:0]; expected_data = ex;
    timeout_cycles = tmo[15:0];
    @(negedge clk);
    // Inputs scrambled after start: the latched values must be used.
    start = 1'b0; op_type = ~op[0]; mode = (md == 0) ? 2'd1 : 2'd0;
    expected_data = ~ex; timeout_cycles = 16'd3;
    for (int j = 0; j < 400; j++) begin
      if (done) begin
        done_seen++;
        if (done_at < 0) begin
          done_at  = j;
          err_seen = int'(error);
        end
      end
      if (error && !done) stray++;
      if (rd_req && first_req < 0) first_req = j;
      we_edge = (j < n);
      if (md == 0 && bwait > 0 && j >= n + bwait) busy_n = 1'b1;
      start = inj && (j == 1);
      if (done_at >= 0 && j > done_at + 3) break;
      @(negedge clk);
    end
    start = 1'b0; we_edge = 1'b0; busy_n = 1'b0;

    if (md == 0) begin
      exp_edge = n + 1 + ((bwait > 1) ? bwait : 1);
      exp_err  = 1'b0;
    end else begin
      model(md, op, ex, last, exp_err);
      exp_edge = n + 1 + (last + 1) * (lat + 1);
    end
    if (tmo + 1 < exp_edge) begin
      exp_edge = tmo + 1;
      exp_err  = 1'b1;
      tmo_hit  = 1'b1;
    end
    check(done_at == exp_edge, tag, "done cycle", done_at, exp_edge);
    check(err_seen == int'(exp_err), tag, "error flag", err_seen, int'(exp_err));
    check(done_seen == 1 && stray == 0, "R10", "done pulses", done_seen * 100 + stray, 100);
    if (md == 0) begin
      check(first_req < 0, "R3", "read issued in ready/busy mode", first_req, -1);
    end else if (!tmo_hit) begin
      check(rd_idx == last + 1, "R11", "reads consumed", rd_idx, last + 1);
      check(first_req == n + 1, "R2", "first read cycle", first_req, n + 1);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] exps [6];
    exps = '{8'h00, 8'h5A, 8'hA5, 8'hFF, 8'h80, 8'h7F};

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!done && !error && !rd_req, "R1", "outputs in reset", {done, error, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !error && !rd_req, "R1", "outputs after reset", {done, error, rd_req}, 0);

    // R4 / R6: bit-7 polling of a program, several words and busy lengths
    for (int e = 0; e < 6; e++) begin
      for (int nb = 0; nb < 4; nb++) begin
        for (int i = 0; i < nb; i++) scr[i] = ~exps[e];
        for (int i = nb; i < nb + 3; i++) scr[i] = exps[e];
        scr_len = nb + 3;
        run("R4", 1, 0, exps[e], 1000, 0, 0, 1'b0);
      end
    end

    // R5: bit-7 polling of an erase
    for (int nb = 0; nb < 4; nb++) begin
      for (int i = 0; i < nb; i++) scr[i] = (i % 2 == 0) ? 8'h00 : 8'h7F;
      for (int i = nb; i < nb + 3; i++) scr[i] = 8'hFF;
      scr_len = nb + 3;
      run("R5", 1, 1, 8'h3C, 1000, 0, 0, 1'b0);
    end

    // R6: confirmation reads that disagree
    scr[0] = 8'hA5; scr[1] = 8'h5A; scr[2] = 8'h5B; scr[3] = 8'h5A; scr_len = 4;
    run("R6", 1, 0, 8'h5A, 1000, 0, 0, 1'b0);
    scr[0] = 8'h5A; scr[1] = 8'h5A; scr[2] = 8'hDA; scr_len = 3;
    run("R6", 1, 0, 8'h5A, 1000, 0, 0, 1'b0);
    scr[0] = 8'h00; scr[1] = 8'hFF; scr[2] = 8'hFF; scr[3] = 8'hEF; scr_len = 4;
    run("R6", 1, 1, 8'h00, 1000, 0, 0, 1'b0);

    // R7: bit-6 toggle polling, both op types, mode codes 2 and 3
    for (int op = 0; op < 2; op++) begin
      for (int nb = 0; nb < 5; nb++) begin
        logic [7:0] want;
        want = (op == 1) ? 8'hFF : 8'h96;
        for (int i = 0; i <= nb; i++) scr[i] = ((i % 2) ? 8'h40 : 8'h00) | 8'(i);
        scr[nb + 1] = scr[nb] ^ 8'h01;
        scr[nb + 2] = want;
        scr[nb + 3] = want;
        scr_len = nb + 4;
        run("R7", 2 + op, op, 8'h96, 1000, 0, 0, nb == 2);
      end
    end
    scr[0] = 8'h00; scr[1] = 8'h40; scr[2] = 8'h40; scr[3] = 8'h96; scr[4] = 8'h86;
    scr_len = 5;
    run("R6", 2, 0, 8'h96, 1000, 0, 0, 1'b0);

    // R3 / R2: ready/busy mode; b = 0 has busy_n high before the pulses end
    for (int op = 0; op < 2; op++) begin
      for (int b = 0; b < 5; b++) begin
        scr[0] = 8'h00; scr_len = 1;
        if (b == 0) run("R2", 0, op, 8'h11, 1000, b, 0, 1'b0);
        else        run("R3", 0, op, 8'h11, 1000, b, 0, b == 3);
      end
    end

    // R8: timeouts
    scr[0] = 8'hA5; scr_len = 1;
    run("R8", 1, 0, 8'h5A, 5, 0, 0, 1'b0);
    run("R8", 1, 0, 8'h5A, 0, 0, 0, 1'b0);
    run("R8", 0, 1, 8'h5A, 20, 1000, 0, 1'b0);
    scr[0] = 8'h00; scr[1] = 8'h40; scr_len = 2;
    run("R8", 1, 1, 8'h00, 9, 0, 2, 1'b0);

    // R11: slow read responses
    scr[0] = 8'hA5; scr[1] = 8'hA5; scr[2] = 8'h5A; scr[3] = 8'h5A; scr[4] = 8'h5A;
    scr_len = 5;
    run("R11", 1, 0, 8'h5A, 1000, 0, 2, 1'b0);
    run("R11", 1, 0, 8'h5A, 1000, 0, 3, 1'b1);
    scr[0] = 8'h00; scr[1] = 8'h40; scr[2] = 8'h00; scr[3] = 8'h00; scr[4] = 8'hFF;
    scr[5] = 8'hFF; scr_len = 6;
    run("R11", 3, 1, 8'h00, 1000, 0, 1, 1'b0);

    // R9: start pulsed while busy, with scrambled inputs
    scr[0] = 8'h3C; scr[1] = 8'hC3; scr[2] = 8'hC3; scr[3] = 8'hC3; scr_len = 4;
    run("R9", 1, 0, 8'hC3, 1000, 0, 0, 1'b1);
    run("R9", 0, 0, 8'hC3, 1000, 2, 0, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule